// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the serial edge of a stereo audio converter. Two streams share one bit clock and one word-select line, both supplied from outside. The transmit stream carries ADC samples toward a host. The receive stream carries DAC samples from the host. Each half of the word-select period holds one channel word, so left and right words alternate on each data line. The block runs on a fast system clock and treats the bit clock and word select as synchronous inputs. It launches a transmit bit one system cycle after it sees a falling bit-clock edge, and it captures a receive bit one system cycle after it sees a rising edge.

A static three-bit format code sets the justification of each stream. The codes cover I2S, MSB-justified, LSB-justified at 16, 18 or 20 bits, and three mixed codes. The mixed codes transmit MSB-justified while they receive LSB-justified words. The word length for I2S and MSB-justified traffic comes from a separate input, limited to 24 and 20 bits respectively. A new format code takes effect only at the start of a stereo frame. Received words appear on a parallel port with a one-cycle valid strobe and a channel flag.

Top module: `audioSerialPort`

## Requirements
- R1: After reset, sdOut is 0 and rxValid is 0. The first bit-clock edges only establish the word-select level. No receive word is reported until a half period that began with a word-select change has finished. No transmit word is sent in the half period in progress when reset is released.
- R2: A half period starts at the first falling bit-clock edge at which word select differs from its level at the previous falling edge. It has 32 bit slots, numbered 0 to 31. sdOut changes only in the system cycle after a falling bit-clock edge. sdIn is captured only in the system cycle after a rising edge.
- R3: Format code 0 (I2S): word select low is the left channel. The word MSB is in slot 1. The length is wordLen, limited to 24, and slot 0 is always zero.
- R4: Format code 1 (MSB-justified): word select high is the left channel. The word MSB is in slot 0. The length is wordLen, limited to 20.
- R5: Format codes 2, 3 and 4 (LSB-justified 16, 18 and 20 bits): word select high is left. The word occupies the last n slots, so its LSB is in slot 31. The transmitter sends bits n-1 down to 0 of the parallel word. The receiver sign-extends the last n captured bits to 24 bits.
- R6: Format codes 5, 6 and 7 (mixed): word select high is left. Transmission is MSB-justified with wordLen limited to 20. Reception is LSB-justified at 16, 18 or 20 bits respectively.
- R7: Every transmit slot outside the word is driven to zero.
- R8: For codes 0 and 1, a received word is placed MSB-first in the top of the 24-bit rxData. Bits below the word length are zero.
- R9: Each completed receive half period gives exactly one single-cycle rxValid pulse. The pulse comes one cycle after the first rising edge of the next half period. rxRight is 1 when the completed half period was the right channel.
- R10: fmtSel is copied to the active format only at a half-period start. That start must be one where word select moves to the left-channel level of the requested code. At other starts the active format is kept.
- R11: The parallel transmit word (txLeft or txRight, chosen by channel) is sampled at slot 0 of its half period. Later changes to it within that half period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 3 | Requested format code (0 to 7) |
| wordLen | input | 5 | Word length for I2S and MSB-justified traffic |
| sclk | input | 1 | Bit clock, synchronous to clk |
| ws | input | 1 | Word select |
| sdIn | input | 1 | Receive serial data from the host |
| txLeft | input | 24 | Left transmit sample |
| txRight | input | 24 | Right transmit sample |
| sdOut | output | 1 | Transmit serial data to the host |
| rxData | output | 24 | Received word |
| rxRight | output | 1 | Received word belongs to the right channel |
| rxValid | output | 1 | One-cycle strobe for rxData and rxRight |

## Verification
Each justification is driven with asymmetric bit patterns in the two channels. A slot shift, a channel swap or a wrong word-select polarity therefore changes the captured vectors. Received LSB words come with both a set and a clear sign bit, which separates sign extension from zero fill. Word lengths above the format limit check the clamping, and a shorter I2S length checks truncation. Separate sequences change the format code in the middle of a frame and change the transmit word in the middle of a half period. Together they show that both are sampled only at their boundaries.

// File: rtl/aspPkg.sv
package aspPkg;
  localparam int SAMPLE_W   = 24;
  localparam int HALF_SLOTS = 32;
  localparam int SLOT_W     = $clog2(HALF_SLOTS);
  localparam int LEN_W      = $clog2(SAMPLE_W + 1);
  localparam int MSB_MAX    = 20;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_MSB   = 3'd1,
    FMT_LSB16 = 3'd2,
    FMT_LSB18 = 3'd3,
    FMT_LSB20 = 3'd4,
    FMT_MIX16 = 3'd5,
    FMT_MIX18 = 3'd6,
    FMT_MIX20 = 3'd7
  } fmtSel_t;

  // Strobes and context from control to datapath
  typedef struct packed {
    logic    txTick;     // falling bit clock seen
    logic    txHalf;     // new transmit half period
    logic    txIsLeft;
    slot_t   txSlot;     // slot now being launched
    fmtSel_t txFmt;
    logic    rxTick;     // rising bit clock seen
    logic    rxHalf;     // new receive half period
    logic    rxClose;    // previous receive half is complete
    logic    rxWasRight;
    fmtSel_t rxFmt;      // format of the half being closed
  } aspCtl_t;

  function automatic logic leftLevel(fmtSel_t f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  function automatic len_t clampLen(len_t wl, int maxLen);
    return (int'(wl) > maxLen) ? len_t'(maxLen) : wl;
  endfunction

  function automatic len_t lsbLen(fmtSel_t f);
    case (f)
      FMT_LSB16, FMT_MIX16: return len_t'(16);
      FMT_LSB18, FMT_MIX18: return len_t'(18);
      default:              return len_t'(20);
    endcase
  endfunction

  function automatic logic txIsLsb(fmtSel_t f);
    return f inside {FMT_LSB16, FMT_LSB18, FMT_LSB20};
  endfunction

  function automatic logic rxIsLsb(fmtSel_t f);
    return !(f inside {FMT_I2S, FMT_MSB});
  endfunction

  function automatic len_t txLen(fmtSel_t f, len_t wl);
    if (f == FMT_I2S) return clampLen(wl, SAMPLE_W);
    if (txIsLsb(f))   return lsbLen(f);
    return clampLen(wl, MSB_MAX);
  endfunction

  function automatic len_t rxLen(fmtSel_t f, len_t wl);
    if (f == FMT_I2S) return clampLen(wl, SAMPLE_W);
    if (f == FMT_MSB) return clampLen(wl, MSB_MAX);
    return lsbLen(f);
  endfunction

  function automatic slot_t txStart(fmtSel_t f, len_t n);
    if (f == FMT_I2S) return slot_t'(1);
    if (txIsLsb(f))   return slot_t'(HALF_SLOTS - int'(n));
    return slot_t'(0);
  endfunction
endpackage

// File: rtl/aspCtl.sv
module aspCtl
  import aspPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    ws,
  input  fmtSel_t fmtReq,
  output aspCtl_t ctl
);
  logic    sclkQ, wsFall, wsRise;
  logic    txSeen, rxSeen, rxArmed, rxLeftQ;
  slot_t   txSlotQ, txSlotNext;
  fmtSel_t fmtAct, fmtNext, rxFmtQ;
  logic    fallTick, riseTick, txHalf, rxHalf;

  assign fallTick = sclkQ & ~sclk;
  assign riseTick = ~sclkQ & sclk;
  assign txHalf   = fallTick & txSeen & (ws != wsFall);
  assign rxHalf   = riseTick & rxSeen & (ws != wsRise);

  always_comb begin
    fmtNext = fmtAct;
    if (txHalf && (ws == leftLevel(fmtReq))) fmtNext = fmtReq;
    if (txHalf)
      txSlotNext = '0;
    else if (txSlotQ == slot_t'(HALF_SLOTS - 1))
      txSlotNext = txSlotQ;
    else
      txSlotNext = txSlotQ + 1'b1;
  end

  always_comb begin
    ctl.txTick     = fallTick;
    ctl.txHalf     = txHalf;
    ctl.txIsLeft   = (ws == leftLevel(fmtNext));
    ctl.txSlot     = txSlotNext;
    ctl.txFmt      = fmtNext;
    ctl.rxTick     = riseTick;
    ctl.rxHalf     = rxHalf;
    ctl.rxClose    = rxHalf & rxArmed;
    ctl.rxWasRight = ~rxLeftQ;
    ctl.rxFmt      = rxFmtQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      wsFall  <= 1'b0;
      wsRise  <= 1'b0;
      txSeen  <= 1'b0;
      rxSeen  <= 1'b0;
      rxArmed <= 1'b0;
      rxLeftQ <= 1'b1;
      txSlotQ <= slot_t'(HALF_SLOTS - 1);
      fmtAct  <= FMT_I2S;
      rxFmtQ  <= FMT_I2S;
    end else begin
      sclkQ <= sclk;
      if (fallTick) begin
        txSeen  <= 1'b1;
        wsFall  <= ws;
        txSlotQ <= txSlotNext;
        fmtAct  <= fmtNext;
      end
      if (riseTick) begin
        rxSeen <= 1'b1;
        wsRise <= ws;
        if (rxHalf) begin
          rxArmed <= 1'b1;
          rxFmtQ  <= fmtAct;
          rxLeftQ <= (ws == leftLevel(fmtAct));
        end
      end
    end
  end
endmodule

// File: rtl/aspData.sv
module aspData
  import aspPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  aspCtl_t             ctl,
  input  len_t                wordLen,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                sdIn,
  output logic                sdOut,
  output logic [SAMPLE_W-1:0] rxData,
  output logic                rxRight,
  output logic                rxValid
);
  // transmit side
  logic [SAMPLE_W-1:0] txWordQ, wordNow;
  len_t                txN, bitIdx;
  slot_t               txSt;
  logic [SLOT_W:0]     txK;
  logic                inWord, txBit;

  always_comb begin
    wordNow = ctl.txHalf ? (ctl.txIsLeft ? txLeft : txRight) : txWordQ;
    txN     = txLen(ctl.txFmt, wordLen);
    txSt    = txStart(ctl.txFmt, txN);
    txK     = {1'b0, ctl.txSlot} - {1'b0, txSt};
    inWord  = (ctl.txSlot >= txSt) && (txK < (SLOT_W+1)'(txN));
    if (txIsLsb(ctl.txFmt))
      bitIdx = txN - 1'b1 - len_t'(txK);
    else
      bitIdx = len_t'(SAMPLE_W - 1) - len_t'(txK);
    txBit = inWord ? wordNow[bitIdx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWordQ <= '0;
      sdOut   <= 1'b0;
    end else if (ctl.txTick) begin
      txWordQ <= wordNow;
      sdOut   <= txBit;
    end
  end

  // receive side
  logic [HALF_SLOTS-1:0] shreg;
  len_t                  rxN, shAmt;
  logic [SAMPLE_W-1:0]   mask, tmp, rxWord;

  always_comb begin
    rxN   = rxLen(ctl.rxFmt, wordLen);
    mask  = ~({SAMPLE_W{1'b1}} >> rxN);
    shAmt = len_t'(SAMPLE_W) - rxN;
    tmp   = shreg[SAMPLE_W-1:0] << shAmt;
    if (rxIsLsb(ctl.rxFmt))
      rxWord = $unsigned($signed(tmp) >>> shAmt);
    else if (ctl.rxFmt == FMT_I2S)
      rxWord = shreg[HALF_SLOTS-2 -: SAMPLE_W] & mask;
    else
      rxWord = shreg[HALF_SLOTS-1 -: SAMPLE_W] & mask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg   <= '0;
      rxData  <= '0;
      rxRight <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctl.rxClose;
      if (ctl.rxClose) begin
        rxData  <= rxWord;
        rxRight <= ctl.rxWasRight;
      end
      if (ctl.rxTick)
        shreg <= ctl.rxHalf ? {{(HALF_SLOTS-1){1'b0}}, sdIn} : {shreg[HALF_SLOTS-2:0], sdIn};
    end
  end
endmodule

// File: rtl/audioSerialPort.sv
module audioSerialPort
  import aspPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  fmtSel,
  input  logic [4:0]  wordLen,
  input  logic        sclk,
  input  logic        ws,
  input  logic        sdIn,
  input  logic [23:0] txLeft,
  input  logic [23:0] txRight,
  output logic        sdOut,
  output logic [23:0] rxData,
  output logic        rxRight,
  output logic        rxValid
);
  aspCtl_t ctl;

  aspCtl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .ws     (ws),
    .fmtReq (fmtSel_t'(fmtSel)),
    .ctl    (ctl)
  );

  aspData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wordLen (wordLen),
    .txLeft  (txLeft),
    .txRight (txRight),
    .sdIn    (sdIn),
    .sdOut   (sdOut),
    .rxData  (rxData),
    .rxRight (rxRight),
    .rxValid (rxValid)
  );
endmodule

// File: rtl/aspChk.sv
module aspChk
  import aspPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclk,
  input logic        sdOut,
  input logic        rxValid,
  input logic [23:0] rxData,
  input logic [4:0]  wordLen,
  input aspCtl_t     ctl
);
  a_r2_launch_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> (!$past(sclk) && $past(sclk, 2)));

  a_r2_capture_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(sclk) && !$past(sclk, 2)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r3_lead_slot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txTick && ctl.txFmt == FMT_I2S && ctl.txSlot == '0) |=> !sdOut);

  a_r5_sign_ext16: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rxClose && ctl.rxFmt inside {FMT_LSB16, FMT_MIX16})
      |=> (rxData[23:15] == '0 || rxData[23:15] == '1));

  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rxClose && ctl.rxFmt inside {FMT_I2S, FMT_MSB})
      |=> ((rxData & ({24{1'b1}} >> rxLen($past(ctl.rxFmt), wordLen))) == '0));

  a_r10_fmt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.txHalf |-> $stable(ctl.txFmt));
endmodule

bind audioSerialPort aspChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclk    (sclk),
  .sdOut   (sdOut),
  .rxValid (rxValid),
  .rxData  (rxData),
  .wordLen (wordLen),
  .ctl     (ctl)
);

// File: tb/sim_audioSerialPort.sv
module sim_audioSerialPort;
  logic        clk = 1'b0;
  logic        rstN, sclk, ws, sdIn;
  logic [2:0]  fmtReq;
  logic [4:0]  wordLen;
  logic [23:0] txLeft, txRight;
  logic        sdOut, rxRight, rxValid;
  logic [23:0] rxData;

  int errors = 0;
  int checks = 0;
  int rxCnt  = 0;
  logic [23:0] lastL = '0, lastR = '0;

  always #2 clk = ~clk;

  audioSerialPort u0 (
    .clk(clk), .rstN(rstN), .fmtSel(fmtReq), .wordLen(wordLen),
    .sclk(sclk), .ws(ws), .sdIn(sdIn), .txLeft(txLeft), .txRight(txRight),
    .sdOut(sdOut), .rxData(rxData), .rxRight(rxRight), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      if (rxRight) lastR = rxData;
      else         lastL = rxData;
      rxCnt++;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected-value model
  function automatic int txN(logic [2:0] f, int wl);
    if (f == 0) return (wl > 24) ? 24 : wl;
    if (f == 2) return 16;
    if (f == 3) return 18;
    if (f == 4) return 20;
    return (wl > 20) ? 20 : wl;
  endfunction

  function automatic int rxN(logic [2:0] f, int wl);
    if (f == 0) return (wl > 24) ? 24 : wl;
    if (f == 1) return (wl > 20) ? 20 : wl;
    if (f == 2 || f == 5) return 16;
    if (f == 3 || f == 6) return 18;
    return 20;
  endfunction

  function automatic logic [31:0] serVec(int st, int n, logic lsb, logic [23:0] w);
    logic [31:0] v = '0;
    for (int s = 0; s < 32; s++) begin
      int k = s - st;
      if (k >= 0 && k < n) v[31-s] = lsb ? w[n-1-k] : w[23-k];
    end
    return v;
  endfunction

  function automatic logic [31:0] expTx(logic [2:0] f, int wl, logic [23:0] w);
    int n = txN(f, wl);
    if (f == 0) return serVec(1, n, 1'b0, w);
    if (f >= 2 && f <= 4) return serVec(32 - n, n, 1'b1, w);
    return serVec(0, n, 1'b0, w);
  endfunction

  function automatic logic [31:0] hostVec(logic [2:0] f, int wl, logic [23:0] h);
    int n = rxN(f, wl);
    if (f == 0) return serVec(1, n, 1'b0, h);
    if (f == 1) return serVec(0, n, 1'b0, h);
    return serVec(32 - n, n, 1'b1, h);
  endfunction

  function automatic logic [23:0] expRx(logic [2:0] f, int wl, logic [23:0] h);
    int n = rxN(f, wl);
    logic [23:0] r;
    if (f <= 1) return h & ~(24'hFFFFFF >> n);
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? h[i] : h[n-1];
    return r;
  endfunction

  task automatic doHalf(input logic lvl, input logic [31:0] hostBits,
                        input logic midChange, input logic [23:0] newL,
                        output logic [31:0] seen);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      sclk = 1'b0; ws = lvl; sdIn = hostBits[31-s];
      if (midChange && s == 4) txLeft = newL;
      @(negedge clk);
      seen[31-s] = sdOut;
      sclk = 1'b1;
    end
  endtask

  task automatic testReset();
    logic [31:0] seen;
    check("R1", "sdOut after reset", {31'b0, sdOut}, 32'd0);
    check("R1", "rxValid after reset", {31'b0, rxValid}, 32'd0);
    doHalf(1'b1, 32'hFFFFFFFF, 1'b0, 24'h0, seen);
    check("R1", "sdOut in first half", seen, 32'd0);
    doHalf(1'b0, 32'hFFFFFFFF, 1'b0, 24'h0, seen);
    check("R1", "no word before a complete half", rxCnt, 32'd0);
  endtask

  task automatic scenario(input string req, input logic [2:0] f, input int wl,
                          input logic [23:0] tL, input logic [23:0] tR,
                          input logic [23:0] hL, input logic [23:0] hR);
    logic [31:0] seen;
    logic lvl;
    int base;
    fmtReq = f; wordLen = 5'(wl); txLeft = tL; txRight = tR;
    lvl = (f == 0) ? 1'b0 : 1'b1;
    doHalf(~lvl, 32'd0, 1'b0, 24'h0, seen);
    base = rxCnt;
    doHalf(lvl, hostVec(f, wl, hL), 1'b0, 24'h0, seen);
    check(req, "left transmit", seen, expTx(f, wl, tL));
    doHalf(~lvl, hostVec(f, wl, hR), 1'b0, 24'h0, seen);
    check(req, "right transmit", seen, expTx(f, wl, tR));
    doHalf(lvl, hostVec(f, wl, hL), 1'b0, 24'h0, seen);
    check(req, "left transmit again", seen, expTx(f, wl, tL));
    check(req, "left receive", {8'h0, lastL}, {8'h0, expRx(f, wl, hL)});
    check(req, "right receive", {8'h0, lastR}, {8'h0, expRx(f, wl, hR)});
    check("R9", "one strobe per half", rxCnt - base, 32'd3);
  endtask

  // R10: a format request made mid-frame waits for the next left edge
  task automatic testFmtChange();
    logic [31:0] seen;
    fmtReq = 3'd1; wordLen = 5'd20; txLeft = 24'hC3A55A; txRight = 24'h3C5AA5;
    doHalf(1'b0, 32'd0, 1'b0, 24'h0, seen);
    doHalf(1'b1, 32'd0, 1'b0, 24'h0, seen);
    check("R10", "left before change", seen, expTx(3'd1, 20, 24'hC3A55A));
    fmtReq = 3'd2;
    doHalf(1'b0, 32'd0, 1'b0, 24'h0, seen);
    check("R10", "right keeps old format", seen, expTx(3'd1, 20, 24'h3C5AA5));
    doHalf(1'b1, 32'd0, 1'b0, 24'h0, seen);
    check("R10", "new format at frame start", seen, expTx(3'd2, 20, 24'hC3A55A));
  endtask

  // R11: transmit word sampled at slot 0 only
  task automatic testMidWord();
    logic [31:0] seen;
    fmtReq = 3'd0; wordLen = 5'd24; txLeft = 24'hFFFFFF; txRight = 24'h000001;
    doHalf(1'b1, 32'd0, 1'b0, 24'h0, seen);
    doHalf(1'b0, 32'd0, 1'b1, 24'h000000, seen);
    check("R11", "word held through half", seen, expTx(3'd0, 24, 24'hFFFFFF));
    doHalf(1'b1, 32'd0, 1'b0, 24'h0, seen);
    check("R11", "right word", seen, expTx(3'd0, 24, 24'h000001));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; sclk = 1'b0; ws = 1'b0; sdIn = 1'b0;
    fmtReq = 3'd0; wordLen = 5'd24; txLeft = 24'h5A5A5A; txRight = 24'hA5A5A5;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    scenario("R2 R3", 3'd0, 24, 24'hA5C3F1, 24'h5A0F3C, 24'h123456, 24'hFEDCBA);
    scenario("R3 R8", 3'd0, 16, 24'h89ABCD, 24'h13579B, 24'h89ABCD, 24'h0F0F0F);
    scenario("R4 R7 R8", 3'd1, 24, 24'hFFFFFF, 24'h800001, 24'h876543, 24'hFFFFFF);
    scenario("R5", 3'd2, 24, 24'h00F0A5, 24'hFF1234, 24'h008001, 24'h007FFF);
    scenario("R5", 3'd3, 24, 24'h02AAAA, 24'h015555, 24'h020001, 24'h01FFFF);
    scenario("R5", 3'd4, 24, 24'h0ABCDE, 24'h012345, 24'h080000, 24'h07FFFF);
    scenario("R6", 3'd6, 20, 24'hDEADBE, 24'h2468AC, 24'h020001, 24'h000003);
    scenario("R6", 3'd5, 18, 24'hF0F0F0, 24'h0F0F0F, 24'h00FFFF, 24'h001234);
    testFmtChange();
    testMidWord();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule